// File: doc/BRIEF.md
# Test-Port Instruction Decode and Data Register Chain

This block holds the instruction and data-register side of a boundary-scan test port on a device that is programmed in system. A separate TAP state machine supplies the capture, shift and update strobes. An 8-bit instruction is shifted in from TDI and becomes active on the update strobe. Its decoded value then picks which data register sits between TDI and TDO. The choices are a one-stage bypass, a 32-bit identification word, a 32-bit user code word, a 10-bit array address, the 89-bit column data register, or the external boundary chain. All registers shift least significant bit first. TDO is registered on the falling edge of the test clock.

The decoded instruction also drives three pin-mode flags: high impedance, clamp and external test. It also drives a select line for the external boundary chain. Two column opcodes move through the array one column at a time. They load the column register and then step the address register on the same update strobe, and they announce the step with a one-cycle pulse. The held address and column values are outputs, so the array logic can use them. They change only on an update strobe or an address step. Reset has the same effect as Test-Logic-Reset: the identification instruction becomes active, so a data scan right after reset returns the identification word.

Top module: `tap_instr_chain`

## Requirements
- R1: While `rst` is high, and at every reset: `active_instr` becomes 0x16, all mode flags and `bsr_select` go low, and `addr_q` and `col_q` clear. A data scan made without any instruction scan then returns the identification value.
- R2: Capture-IR loads the pattern 0000_0001 into the instruction shift stage. Each Shift-IR cycle moves TDI in at the MSB end and shows the LSB on TDO after the falling clock edge. The first bit out is therefore 1, followed by seven 0 bits.
- R3: `active_instr` changes only on an Update-IR cycle. Shifting a new code without an update leaves the active instruction and its flags unchanged.
- R4: Every code with bit 7 set selects the bypass stage. That stage captures 0 and delays TDI by exactly one shift cycle.
- R5: Code 0x16 selects the 32-bit identification register, which captures the `ID_VALUE` parameter. No mode flag or boundary select is raised.
- R6: Code 0x17 selects a 32-bit register that captures `usercode_in`.
- R7: Code 0x01 selects the 10-bit address register. Capture-DR loads the current `addr_q`, and Update-DR copies the shifted value to `addr_q`. A scan without an update leaves `addr_q` unchanged.
- R8: Codes 0x02, 0x07 and 0x0A select the 89-bit column register. Capture-DR loads `col_rd_in`, and Update-DR copies the shifted value to `col_q`.
- R9: Codes 0x27 and 0x2A use the column register as in R8. On the same Update-DR they also raise `addr_q` by one, modulo 1024, and hold `addr_incr` high for exactly one cycle. No other code steps the address.
- R10: Code 0x00 raises `extest_mode` and `bsr_select`, and routes `bsr_tdo` to TDO. Code 0x1C raises `bsr_select` only.
- R11: Code 0x18 raises `hiz_mode`. Codes 0x20 and 0x30 raise `clamp_mode`. All three select the bypass stage, and at most one mode flag is ever high.
- R12: Every other code with bit 7 clear (for example 0x55) selects the bypass stage and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (Test-Logic-Reset) |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| usercode_in | input | 32 | User code word read from non-volatile cells |
| col_rd_in | input | 89 | Column word read from the array |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| active_instr | output | 8 | Instruction currently in force |
| bsr_select | output | 1 | Boundary chain is the selected data register |
| hiz_mode | output | 1 | All outputs must float |
| clamp_mode | output | 1 | Pins are driven from the boundary register |
| extest_mode | output | 1 | External test mode |
| addr_q | output | 10 | Held array address |
| col_q | output | 89 | Held column data for the array |
| addr_incr | output | 1 | One-cycle pulse when the address steps |

## Verification
The hardest situation to reach from the ports is the address wrap from 0x3FF to 0. Getting there takes three scans in a row: an address scan that loads 0x3FF, an instruction scan to an incrementing column opcode, and a full 89-bit column scan ending in an update. The stimulus also separates the instruction shift from its update strobe, to show that a shifted code stays inactive until the update. Every serial bit expected on TDO is queued by the driver, so capture values, bypass delay and boundary routing are all compared bit by bit as they leave the port.

// File: rtl/tap_chain_pkg.sv
package tap_chain_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
    localparam logic [IR_W-1:0] OP_ADDR     = 8'h01;
    localparam logic [IR_W-1:0] OP_COL      = 8'h02;
    localparam logic [IR_W-1:0] OP_PROG     = 8'h07;
    localparam logic [IR_W-1:0] OP_VERIFY   = 8'h0A;
    localparam logic [IR_W-1:0] OP_IDCODE   = 8'h16;
    localparam logic [IR_W-1:0] OP_USER     = 8'h17;
    localparam logic [IR_W-1:0] OP_HIZ      = 8'h18;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h1C;
    localparam logic [IR_W-1:0] OP_CLAMP    = 8'h20;
    localparam logic [IR_W-1:0] OP_PROG_INC = 8'h27;
    localparam logic [IR_W-1:0] OP_VER_INC  = 8'h2A;
    localparam logic [IR_W-1:0] OP_NOOP     = 8'h30;

    localparam logic [IR_W-1:0] IR_CAPTURE  = 8'h01;

    typedef enum logic [2:0] {
        DR_BYP,
        DR_BSR,
        DR_ID,
        DR_USR,
        DR_ADR,
        DR_COL
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    hiz;
        logic    clamp;
        logic    extest;
        logic    incr;
    } ir_dec_t;

    function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
        ir_dec_t d;
        d.sel    = DR_BYP;
        d.hiz    = 1'b0;
        d.clamp  = 1'b0;
        d.extest = 1'b0;
        d.incr   = 1'b0;
        if (!op[IR_W-1]) begin
            case (op)
                OP_EXTEST: begin
                    d.sel    = DR_BSR;
                    d.extest = 1'b1;
                end
                OP_SAMPLE:               d.sel = DR_BSR;
                OP_IDCODE:               d.sel = DR_ID;
                OP_USER:                 d.sel = DR_USR;
                OP_ADDR:                 d.sel = DR_ADR;
                OP_COL, OP_PROG, OP_VERIFY: d.sel = DR_COL;
                OP_PROG_INC, OP_VER_INC: begin
                    d.sel  = DR_COL;
                    d.incr = 1'b1;
                end
                OP_HIZ:                  d.hiz = 1'b1;
                OP_CLAMP, OP_NOOP:       d.clamp = 1'b1;
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/tap_ir.sv
module tap_ir
    import tap_chain_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tdi,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so,
    output ir_dec_t         dec
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            if (capture_ir) begin
                ir_sr <= IR_CAPTURE;
            end else if (shift_ir) begin
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            end
            if (update_ir) begin
                ir_q <= ir_sr;
            end
        end
    end

    assign ir_so = ir_sr[0];
    assign dec   = decode_op(ir_q);

    AST_IR_RESET: assert property (@(posedge clk) rst |=> (ir_q == OP_IDCODE))
        else $error("instruction not IDCODE after reset"); // R1

    AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        capture_ir |=> (ir_so == 1'b1))
        else $error("capture pattern LSB not 1"); // R2

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !update_ir |=> $stable(ir_q))
        else $error("instruction changed without update"); // R3

endmodule

// File: rtl/tap_wordreg.sv
module tap_wordreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tdi,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic [W-1:0] cap_val,
    output logic         so
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture_en) begin
            sr <= cap_val;
        end else if (shift_en) begin
            sr <= {tdi, sr[W-1:1]};
        end
    end

    assign so = sr[0];

endmodule

// File: rtl/tap_updreg.sv
module tap_updreg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tdi,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic         update_en,
    input  logic         inc_en,
    input  logic [W-1:0] cap_val,
    output logic         so,
    output logic [W-1:0] upd_q
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture_en) begin
            sr <= cap_val;
        end else if (shift_en) begin
            sr <= {tdi, sr[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= '0;
        end else if (update_en) begin
            upd_q <= sr;
        end else if (inc_en) begin
            upd_q <= upd_q + W'(1);
        end
    end

    assign so = sr[0];

    AST_UPD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!update_en && !inc_en) |=> $stable(upd_q))
        else $error("held value changed without update or step"); // R7

endmodule

// File: rtl/tap_instr_chain.sv
module tap_instr_chain
    import tap_chain_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter int          COL_W    = 89,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h1358_E04B
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tdi,
    input  logic              capture_ir,
    input  logic              shift_ir,
    input  logic              update_ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              bsr_tdo,
    input  logic [WORD_W-1:0] usercode_in,
    input  logic [COL_W-1:0]  col_rd_in,
    output logic              tdo,
    output logic [IR_W-1:0]   active_instr,
    output logic              bsr_select,
    output logic              hiz_mode,
    output logic              clamp_mode,
    output logic              extest_mode,
    output logic [ADDR_W-1:0] addr_q,
    output logic [COL_W-1:0]  col_q,
    output logic              addr_incr
);

    ir_dec_t dec;
    logic    ir_so;
    logic    word_so, addr_so, col_so;
    logic    byp_q;
    logic    dr_so;
    logic    sel_word, sel_adr, sel_col, sel_byp;

    tap_ir u_ir (
        .clk        (tck),
        .rst        (rst),
        .tdi        (tdi),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir),
        .ir_q       (active_instr),
        .ir_so      (ir_so),
        .dec        (dec)
    );

    assign sel_word = (dec.sel == DR_ID) || (dec.sel == DR_USR);
    assign sel_adr  = (dec.sel == DR_ADR);
    assign sel_col  = (dec.sel == DR_COL);
    assign sel_byp  = (dec.sel == DR_BYP);

    // identification and user code share one 32-bit shift stage
    tap_wordreg #(.W(WORD_W)) u_word (
        .clk        (tck),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_dr && sel_word),
        .shift_en   (shift_dr && sel_word),
        .cap_val    ((dec.sel == DR_USR) ? usercode_in : ID_VALUE[WORD_W-1:0]),
        .so         (word_so)
    );

    tap_updreg #(.W(ADDR_W)) u_addr (
        .clk        (tck),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_dr && sel_adr),
        .shift_en   (shift_dr && sel_adr),
        .update_en  (update_dr && sel_adr),
        .inc_en     (update_dr && dec.incr),
        .cap_val    (addr_q),
        .so         (addr_so),
        .upd_q      (addr_q)
    );

    tap_updreg #(.W(COL_W)) u_col (
        .clk        (tck),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_dr && sel_col),
        .shift_en   (shift_dr && sel_col),
        .update_en  (update_dr && sel_col),
        .inc_en     (1'b0),
        .cap_val    (col_rd_in),
        .so         (col_so),
        .upd_q      (col_q)
    );

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (capture_dr && sel_byp) begin
            byp_q <= 1'b0;
        end else if (shift_dr && sel_byp) begin
            byp_q <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            addr_incr <= 1'b0;
        end else begin
            addr_incr <= update_dr && dec.incr;
        end
    end

    always_comb begin
        case (dec.sel)
            DR_BSR:        dr_so = bsr_tdo;
            DR_ID, DR_USR: dr_so = word_so;
            DR_ADR:        dr_so = addr_so;
            DR_COL:        dr_so = col_so;
            default:       dr_so = byp_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo <= 1'b0;
        end else begin
            tdo <= shift_ir ? ir_so : dr_so;
        end
    end

    assign bsr_select  = (dec.sel == DR_BSR);
    assign hiz_mode    = dec.hiz;
    assign clamp_mode  = dec.clamp;
    assign extest_mode = dec.extest;

    AST_BYP_ZERO: assert property (@(posedge tck) disable iff (rst)
        (capture_dr && sel_byp) |=> (byp_q == 1'b0))
        else $error("bypass did not capture zero"); // R4

    AST_ADDR_STEP: assert property (@(posedge tck) disable iff (rst)
        addr_incr |-> (addr_q == ADDR_W'($past(addr_q) + 1'b1)))
        else $error("address step pulse without +1"); // R9

    AST_MODE_EXCL: assert property (@(posedge tck) disable iff (rst)
        $onehot0({hiz_mode, clamp_mode, extest_mode}))
        else $error("more than one pin mode active"); // R11

endmodule

// File: tb/tap_instr_chain_test.sv
`timescale 1ns/1ps
module tap_instr_chain_test;

    localparam int          ADDR_W = 10;
    localparam int          COL_W  = 89;
    localparam logic [31:0] ID_V   = 32'h1358_E04B;
    localparam logic [88:0] COL_A  = {25'h1F0F0F, 64'hDEAD_BEEF_CAFE_F00D};
    localparam logic [88:0] COL_B  = {25'h0123AB, 64'h5A5A_0FF0_1234_8765};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
    logic capture_ir = 0, shift_ir = 0, update_ir = 0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic [31:0]       usercode_in = 32'hC3A5_0F96;
    logic [COL_W-1:0]  col_rd_in   = {25'h0ABCDEF, 64'h0123_4567_89AB_CDEF};
    logic              tdo, bsr_select, hiz_mode, clamp_mode, extest_mode, addr_incr;
    logic [7:0]        active_instr;
    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  col_q;

    int checks = 0, errors = 0;
    bit mon_on = 1'b0, done = 1'b0;
    logic  exp_bits[$];
    string exp_tags[$];
    logic  mon_e;
    string mon_t;

    tap_instr_chain #(.ID_VALUE(ID_V)) uut (
        .tck(clk), .rst(rst), .tdi(tdi),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .bsr_tdo(bsr_tdo), .usercode_in(usercode_in), .col_rd_in(col_rd_in),
        .tdo(tdo), .active_instr(active_instr), .bsr_select(bsr_select),
        .hiz_mode(hiz_mode), .clamp_mode(clamp_mode), .extest_mode(extest_mode),
        .addr_q(addr_q), .col_q(col_q), .addr_incr(addr_incr)
    );

    // monitor: pops one expected TDO bit per shift cycle
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            checks++;
            if (exp_bits.size() == 0) begin
                errors++;
                $display("FAIL monitor: unexpected shift bit got %b expected none", tdo);
            end else begin
                mon_e = exp_bits.pop_front();
                mon_t = exp_tags.pop_front();
                if (tdo !== mon_e) begin
                    errors++;
                    $display("FAIL %s: tdo got %b expected %b", mon_t, tdo, mon_e);
                end
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_flags(input string tag, input logic [7:0] ins,
                               input logic bsr, input logic hz, input logic cl, input logic ex);
        chk(tag, {active_instr, bsr_select, hiz_mode, clamp_mode, extest_mode},
                 {ins, bsr, hz, cl, ex});
    endtask

    task automatic do_update_ir;
        update_ir = 1'b1;
        tick();
        update_ir = 1'b0;
    endtask

    task automatic scan_ir(input logic [7:0] op, input string tag, input bit upd);
        capture_ir = 1'b1;
        tick();
        capture_ir = 1'b0;
        shift_ir   = 1'b1;
        mon_on     = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tdi = op[i];
            exp_bits.push_back(8'h01 >> i);
            exp_tags.push_back(tag);
            tick();
        end
        shift_ir = 1'b0;
        mon_on   = 1'b0;
        if (upd) do_update_ir();
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, input logic [127:0] dexp,
                           input bit from_bsr, input string tag, input bit upd);
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        mon_on     = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = din[i];
            if (from_bsr) bsr_tdo = din[i];
            exp_bits.push_back(from_bsr ? din[i] : dexp[i]);
            exp_tags.push_back(tag);
            tick();
        end
        shift_dr = 1'b0;
        mon_on   = 1'b0;
        bsr_tdo  = 1'b0;
        if (upd) begin
            update_dr = 1'b1;
            tick();
            update_dr = 1'b0;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        check_flags("R1 reset flags", 8'h16, 0, 0, 0, 0);
        chk("R1 reset addr", addr_q, 0);
        chk("R1 reset col", col_q, 0);
        rst = 1'b0;
        tick();
        scan_dr(32, 0, ID_V, 0, "R1 R5 id after reset", 0);

        // R2 R3: shift without update, then update
        scan_ir(8'h17, "R2 ir capture pattern", 0);
        check_flags("R3 no update yet", 8'h16, 0, 0, 0, 0);
        do_update_ir();
        check_flags("R3 after update", 8'h17, 0, 0, 0, 0);
        scan_dr(32, 32'h0, usercode_in, 0, "R6 usercode", 1);

        scan_ir(8'h16, "R2 ir", 1);
        check_flags("R5 functional mode", 8'h16, 0, 0, 0, 0);
        scan_dr(32, 32'hFFFF_0000, ID_V, 0, "R5 id", 0);

        // R4 bypass for top bit set
        scan_ir(8'hA5, "R2 ir", 1);
        check_flags("R4 flags", 8'hA5, 0, 0, 0, 0);
        scan_dr(16, 16'hB3C1, 128'hB3C1 << 1, 0, "R4 bypass A5", 0);
        scan_ir(8'hFF, "R2 ir", 1);
        scan_dr(8, 8'h6A, 128'h6A << 1, 0, "R4 bypass FF", 0);

        // R12 undefined code
        scan_ir(8'h55, "R2 ir", 1);
        check_flags("R12 flags", 8'h55, 0, 0, 0, 0);
        scan_dr(12, 12'h9E7, 128'h9E7 << 1, 0, "R12 bypass 55", 0);

        // R7 address register
        scan_ir(8'h01, "R2 ir", 1);
        scan_dr(10, 10'h2C5, 10'h000, 0, "R7 capture addr", 1);
        chk("R7 addr updated", addr_q, 10'h2C5);
        chk("R9 no step on addr update", addr_incr, 0);
        scan_dr(10, 10'h0F0, 10'h2C5, 0, "R7 readback", 0);
        chk("R7 hold without update", addr_q, 10'h2C5);

        // R8 column register
        scan_ir(8'h02, "R2 ir", 1);
        scan_dr(89, COL_A, col_rd_in, 0, "R8 column capture", 1);
        chk("R8 col updated", col_q, COL_A);
        chk("R9 no step for 02", {addr_incr, addr_q}, {1'b0, 10'h2C5});

        // R9 incrementing opcodes
        scan_ir(8'h27, "R2 ir", 1);
        scan_dr(89, COL_B, col_rd_in, 0, "R9 prog incr capture", 1);
        chk("R9 pulse 27", {addr_incr, addr_q}, {1'b1, 10'h2C6});
        chk("R9 col loaded 27", col_q, COL_B);
        tick();
        chk("R9 pulse one cycle", addr_incr, 0);
        scan_ir(8'h2A, "R2 ir", 1);
        scan_dr(89, COL_A, col_rd_in, 0, "R9 verify incr capture", 1);
        chk("R9 pulse 2A", {addr_incr, addr_q}, {1'b1, 10'h2C7});
        tick();

        // R9 wrap at top of address range
        scan_ir(8'h01, "R2 ir", 1);
        scan_dr(10, 10'h3FF, 10'h2C7, 0, "R7 readback before wrap", 1);
        scan_ir(8'h27, "R2 ir", 1);
        scan_dr(89, COL_B, col_rd_in, 0, "R9 capture before wrap", 1);
        chk("R9 wrap", {addr_incr, addr_q}, {1'b1, 10'h000});
        tick();
        scan_ir(8'h07, "R2 ir", 1);
        scan_dr(89, COL_A, col_rd_in, 0, "R8 program op capture", 1);
        chk("R9 no step for 07", {addr_incr, addr_q}, {1'b0, 10'h000});
        chk("R8 col via 07", col_q, COL_A);

        // R10 boundary chain
        scan_ir(8'h00, "R2 ir", 1);
        check_flags("R10 extest flags", 8'h00, 1, 0, 0, 1);
        scan_dr(20, 20'hA5C3E, 0, 1, "R10 extest route", 0);
        scan_ir(8'h1C, "R2 ir", 1);
        check_flags("R10 sample flags", 8'h1C, 1, 0, 0, 0);
        scan_dr(6, 6'h2D, 0, 1, "R10 sample route", 0);

        // R11 pin modes
        scan_ir(8'h18, "R2 ir", 1);
        check_flags("R11 hiz flags", 8'h18, 0, 1, 0, 0);
        scan_dr(9, 9'h1B3, 128'h1B3 << 1, 0, "R11 hiz bypass", 0);
        scan_ir(8'h20, "R2 ir", 1);
        check_flags("R11 clamp flags", 8'h20, 0, 0, 1, 0);
        scan_dr(9, 9'h0CA, 128'h0CA << 1, 0, "R11 clamp bypass", 0);
        scan_ir(8'h30, "R2 ir", 1);
        check_flags("R11 noop flags", 8'h30, 0, 0, 1, 0);
        scan_dr(9, 9'h155, 128'h155 << 1, 0, "R11 noop bypass", 0);

        // R1 reset later in the run
        scan_ir(8'h55, "R2 ir", 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_flags("R1 second reset", 8'h16, 0, 0, 0, 0);
        chk("R1 second reset addr", addr_q, 0);
        tick();
        scan_dr(32, 0, ID_V, 0, "R1 id after second reset", 0);

        tick();
        chk("scoreboard drained", exp_bits.size(), 0);
        finish_run();
    end

endmodule